// File: doc/BRIEF.md
# Programmable 32-Source Interrupt Controller

This block gathers 32 external interrupt lines and presents them to a processor through a small word-addressed register bus. Software chooses, line by line, whether a request is sensed as a level or as an edge. It also chooses which polarity counts as active, whether the line may reach the processor at all, and whether it goes out on the ordinary interrupt pin or on the machine-check pin.

Every line is first resynchronised to the controller clock. Requests are then latched into a status register, and software acknowledges them by writing ones to that register. A masked view of the status register, two registered interrupt outputs and a vector register all follow from the latched state. The vector register names the most urgent pending request, so a handler can dispatch without scanning bits.

Bit numbering is reversed: source n lives at bit 31-n, so source 0 is the most significant bit. Sources 17, 18 and 19 are reserved and never take part.

Top module: `pirq_ctl`

Register word addresses on `bus_addr`: 0 status (write 1 to clear), 1 enable, 2 masked status (read only), 3 trigger type, 4 polarity, 5 routing, 6 vector (read only). Any other address reads zero.

## Requirements
- R1: Source n occupies bit 31-n of every per-source register. Source 0 is bit 31 and source 31 is bit 0.
- R2: Sources 17, 18 and 19 (bits 14, 13 and 12) always read zero in status and masked status. They never drive `int_o` or `mchk_o`, whatever their line, enable or routing.
- R3: Writing status with a 1 in a bit clears that latched request. A 0 in a bit leaves it as it was.
- R4: A level-sensitive source (trigger bit 0) sets its status bit on every cycle its synchronised line is active. A clear therefore only sticks once the line is inactive. A set and a clear landing in the same cycle leave the bit set.
- R5: An edge-triggered source (trigger bit 1) sets its status bit once per detected transition. Polarity 1 selects rising edges and polarity 0 selects falling edges. The opposite transition and a steady line set nothing.
- R6: For a level-sensitive source, polarity 0 means the line is active when low and polarity 1 means it is active when high.
- R7: Masked status reads as the bitwise AND of status and enable.
- R8: A routing bit of 1 sends the masked request to `int_o`, and 0 sends it to `mchk_o`. Each output is the OR of its masked, routed bits, registered one clock after the status or control change.
- R9: The vector register reads the number of the lowest-numbered source that is both pending and enabled, zero-extended to 32 bits. It reads all ones when no such source exists.
- R10: After reset, enable, status, trigger and polarity are all zero, routing is all ones, the vector reads all ones, and both outputs are low.
- R11: Each line passes through a two-flop synchroniser. A change on a line that is already configured reaches the status register on the third rising clock edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_in | input | 32 | Asynchronous request lines, source n on bit 31-n |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high together with bus_sel |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| int_o | output | 1 | Ordinary interrupt request, registered |
| mchk_o | output | 1 | Machine-check request, registered |

## Verification
The clash that matters is a software clear and a freshly detected request arriving on the same clock edge for the same status bit. The bench makes a second falling edge on an edge-triggered source whose bit is already pending. It applies the line change two clocks ahead of a write of one to that bit, so the synchroniser delivers the edge exactly as the clear is latched. The bit must still read as set afterwards. A later clear with no edge behind it must then remove the bit.

// File: rtl/pirq_pkg.sv
// Shared constants for the interrupt controller: source count, register
// address map and a helper that builds the reserved-source bit mask.
// Assumes reversed numbering: source n sits at bit (NSRC-1-n).
package pirq_pkg;

    localparam int NSRC = 32;
    localparam int AW   = 3;

    localparam logic [AW-1:0] A_STAT  = 3'd0;
    localparam logic [AW-1:0] A_ENAB  = 3'd1;
    localparam logic [AW-1:0] A_MSTAT = 3'd2;
    localparam logic [AW-1:0] A_TRIG  = 3'd3;
    localparam logic [AW-1:0] A_POL   = 3'd4;
    localparam logic [AW-1:0] A_ROUTE = 3'd5;
    localparam logic [AW-1:0] A_VEC   = 3'd6;

    // Build the bit mask of reserved sources lo..hi in reversed numbering.
    function automatic logic [NSRC-1:0] rsv_mask(input int lo, input int hi);
        logic [NSRC-1:0] m;
        m = '0;
        for (int n = 0; n < NSRC; n++) begin
            if (n >= lo && n <= hi) m[NSRC-1-n] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/pirq_sync.sv
// Multi-stage synchroniser for a bus of independent asynchronous lines.
// Assumes each bit is unrelated to the others (no bus coherency needed).
// Reset loads RST_VAL so that idle-high lines look inactive at start-up.
module pirq_sync #(
    parameter int          W       = 32,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);

    logic [W-1:0] chain_q [STAGES];

    // Shift the raw lines through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain_q[i] <= RST_VAL;
        end else begin
            chain_q[0] <= d_async;
            for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
        end
    end

    assign d_sync = chain_q[STAGES-1];

endmodule

// File: rtl/pirq_detect.sv
// Per-source request detection and the write-one-to-clear status register.
// Level sources set their bit every cycle they are active; edge sources set
// it on one synchronised transition. A set beats a clear in the same cycle.
// Assumes line_s is already synchronous to clk. Reserved bits never latch.
module pirq_detect #(
    parameter int          N   = 32,
    parameter logic [N-1:0] RSV = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] line_s,
    input  logic [N-1:0] trig,
    input  logic [N-1:0] pol,
    input  logic         clr_we,
    input  logic [N-1:0] clr_bits,
    output logic [N-1:0] stat_q
);

    logic [N-1:0] prev_q;
    logic [N-1:0] set_vec;
    logic [N-1:0] clr_vec;

    // Form one set request per bit from trigger type and polarity.
    for (genvar g = 0; g < N; g++) begin : g_bit
        if (RSV[g]) begin : g_rsv
            assign set_vec[g] = 1'b0;
        end else begin : g_live
            logic lvl_hit;
            logic edge_hit;
            assign lvl_hit  = pol[g] ? line_s[g] : ~line_s[g];
            assign edge_hit = pol[g] ? (line_s[g] & ~prev_q[g])
                                     : (~line_s[g] & prev_q[g]);
            assign set_vec[g] = trig[g] ? edge_hit : lvl_hit;
        end
    end

    assign clr_vec = clr_we ? clr_bits : '0;

    // Hold the previous line state and update the latched requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '1;
            stat_q <= '0;
        end else begin
            prev_q <= line_s;
            stat_q <= ((stat_q & ~clr_vec) | set_vec) & ~RSV;
        end
    end

    p_rsv_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q & RSV) == '0);

    p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((stat_q & $past(clr_bits & ~set_vec)) == '0));

    p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((stat_q & $past(set_vec)) == $past(set_vec)));

endmodule

// File: rtl/pirq_prio.sv
// Fixed-priority encoder over reversed-numbered requests: the highest bit
// (lowest source number) wins. Purely combinational.
module pirq_prio #(
    parameter int N  = 32,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          vld,
    output logic [IW-1:0] idx
);

    // Scan from the least urgent bit so the most urgent match is kept last.
    always_comb begin
        vld = 1'b0;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i]) begin
                vld = 1'b1;
                idx = IW'(N - 1 - i);
            end
        end
    end

endmodule

// File: rtl/pirq_ctl.sv
// Top of the interrupt controller: register file and bus decode, the input
// synchroniser, request detection, masking, routing to two registered
// outputs, and the priority vector. Reads are combinational on bus_addr;
// writes take effect on the clock edge where bus_sel and bus_we are high.
module pirq_ctl
    import pirq_pkg::*;
#(
    parameter int RSV_LO      = 17,
    parameter int RSV_HI      = 19,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] irq_in,
    input  logic            bus_sel,
    input  logic            bus_we,
    input  logic [AW-1:0]   bus_addr,
    input  logic [NSRC-1:0] bus_wdata,
    output logic [NSRC-1:0] bus_rdata,
    output logic            int_o,
    output logic            mchk_o
);

    localparam logic [NSRC-1:0] RSV = rsv_mask(RSV_LO, RSV_HI);
    localparam int              IW  = $clog2(NSRC);

    logic [NSRC-1:0] en_q, trig_q, pol_q, route_q;
    logic [NSRC-1:0] line_s, stat_w, mstat_w;
    logic            wr_hit, clr_we;
    logic            vec_vld;
    logic [IW-1:0]   vec_idx;
    logic [NSRC-1:0] vec_word;

    assign wr_hit = bus_sel & bus_we;
    assign clr_we = wr_hit && (bus_addr == A_STAT);

    pirq_sync #(
        .W       (NSRC),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ('1)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (irq_in),
        .d_sync  (line_s)
    );

    pirq_detect #(
        .N   (NSRC),
        .RSV (RSV)
    ) u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_s   (line_s),
        .trig     (trig_q),
        .pol      (pol_q),
        .clr_we   (clr_we),
        .clr_bits (bus_wdata),
        .stat_q   (stat_w)
    );

    assign mstat_w = stat_w & en_q;

    pirq_prio #(.N(NSRC)) u_prio (
        .req (mstat_w),
        .vld (vec_vld),
        .idx (vec_idx)
    );

    assign vec_word = vec_vld ? {{(NSRC-IW){1'b0}}, vec_idx} : '1;

    // Update the software-written control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= '0;
            trig_q  <= '0;
            pol_q   <= '0;
            route_q <= '1;
        end else if (wr_hit) begin
            if (bus_addr == A_ENAB)  en_q    <= bus_wdata;
            if (bus_addr == A_TRIG)  trig_q  <= bus_wdata;
            if (bus_addr == A_POL)   pol_q   <= bus_wdata;
            if (bus_addr == A_ROUTE) route_q <= bus_wdata;
        end
    end

    // Register the two request outputs from the routed masked status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_o  <= 1'b0;
            mchk_o <= 1'b0;
        end else begin
            int_o  <= |(mstat_w & route_q);
            mchk_o <= |(mstat_w & ~route_q);
        end
    end

    // Select the read data for the addressed register.
    always_comb begin
        case (bus_addr)
            A_STAT:  bus_rdata = stat_w;
            A_ENAB:  bus_rdata = en_q;
            A_MSTAT: bus_rdata = mstat_w;
            A_TRIG:  bus_rdata = trig_q;
            A_POL:   bus_rdata = pol_q;
            A_ROUTE: bus_rdata = route_q;
            A_VEC:   bus_rdata = vec_word;
            default: bus_rdata = '0;
        endcase
    end

    p_mstat_view_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_MSTAT) |-> (bus_rdata == (stat_w & en_q)));

    p_int_route_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (int_o == |($past(stat_w & en_q & route_q))));

    p_mchk_route_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (mchk_o == |($past(stat_w & en_q & ~route_q))));

    p_vec_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        vec_vld |-> (mstat_w[NSRC-1-int'(vec_idx)]
                     && ((mstat_w >> (NSRC - int'(vec_idx))) == '0)));

    p_vec_none_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mstat_w == '0) |-> (vec_word == '1));

endmodule

// File: tb/sim_pirq_ctl.sv
// Scoreboard bench: driver tasks push expected items, a monitor pops them a
// quarter period after each falling edge and compares against the ports.
module sim_pirq_ctl;

    localparam int CLK_PER = 10;
    localparam int K_INT   = 7;
    localparam int K_MCHK  = 8;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '1;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        int_o, mchk_o;

    item_t q[$];
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    pirq_ctl u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .int_o     (int_o),
        .mchk_o    (mchk_o)
    );

    function automatic logic [31:0] b(input int n);
        return 32'h1 << (31 - n);
    endfunction

    task automatic line(input int n, input logic v);
        @(negedge clk);
        irq_in[31-n] = v;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic chk(input int kind, input logic [31:0] exp, input string tag);
        item_t it;
        @(negedge clk);
        if (kind < K_INT) bus_addr = 3'(kind);
        it.kind = kind; it.exp = exp; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pop one expected item per cycle and compare it with the ports.
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PER/4);
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = q.pop_front();
                if (it.kind == K_INT)       act = {31'b0, int_o};
                else if (it.kind == K_MCHK) act = {31'b0, mchk_o};
                else                        act = bus_rdata;
                n_chk++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %08h expected %08h", it.tag, act, it.exp);
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        chk(0, 32'h0, "R10 status");
        chk(1, 32'h0, "R10 enable");
        chk(3, 32'h0, "R10 trigger");
        chk(4, 32'h0, "R10 polarity");
        chk(5, 32'hFFFF_FFFF, "R10 routing");
        chk(6, 32'hFFFF_FFFF, "R10 vector");
        chk(K_INT, 0, "R10 int_o");
        chk(K_MCHK, 0, "R10 mchk_o");

        // R11 / R6 / R1: active-low level on source 3, three-edge latency
        line(3, 1'b0);
        chk(0, 32'h0, "R11 not yet after one edge");
        chk(0, 32'h0, "R11 not yet after two edges");
        chk(0, b(3), "R11 R6 R1 set on third edge");
        chk(2, 32'h0, "R7 masked view while disabled");
        chk(6, 32'hFFFF_FFFF, "R9 none while disabled");

        // R4: clear while level still active is overridden
        wr(0, b(3));
        chk(0, b(3), "R4 level re-asserts");
        line(3, 1'b1);
        idle(4);
        wr(0, 32'h0);
        chk(0, b(3), "R3 write zero keeps bit");
        wr(0, b(3));
        chk(0, 32'h0, "R3 write one clears bit");

        // R6: active-high level on source 7 (line idles high)
        wr(4, b(7));
        chk(0, b(7), "R6 active-high level sets");
        line(7, 1'b0);
        idle(4);
        wr(0, b(7));
        chk(0, 32'h0, "R6 inactive low line stays clear");

        // R5: rising-edge source 5
        wr(3, b(5));
        wr(4, b(7) | b(5));
        idle(4);
        chk(0, 32'h0, "R5 steady line sets nothing");
        line(5, 1'b0);
        idle(4);
        chk(0, 32'h0, "R5 falling edge ignored in rising mode");
        line(5, 1'b1);
        idle(3);
        chk(0, b(5), "R5 rising edge sets");
        wr(0, b(5));
        chk(0, 32'h0, "R5 edge source stays cleared");

        // R7 / R8 / R9: enable and route
        wr(1, b(5) | b(3) | b(0) | b(31));
        line(5, 1'b0);
        idle(4);
        line(5, 1'b1);
        idle(4);
        chk(2, b(5), "R7 masked status");
        chk(6, 32'd5, "R9 vector source 5");
        chk(K_INT, 1, "R8 routed to int_o");
        chk(K_MCHK, 0, "R8 mchk_o idle");
        wr(5, ~b(5));
        chk(K_MCHK, 1, "R8 routed to mchk_o");
        chk(K_INT, 0, "R8 int_o dropped");

        // R9 priority between sources
        line(3, 1'b0);
        idle(4);
        chk(0, b(5) | b(3), "R1 two pending");
        chk(6, 32'd3, "R9 lower number wins");
        chk(K_INT, 1, "R8 both outputs int");
        chk(K_MCHK, 1, "R8 both outputs mchk");
        line(31, 1'b0);
        idle(4);
        chk(6, 32'd3, "R9 source 31 loses");
        line(3, 1'b1);
        idle(4);
        wr(0, b(3) | b(5));
        chk(0, b(31), "R1 source 31 at bit 0");
        chk(6, 32'd31, "R9 vector source 31");

        // R5 falling edge on source 0, then R9 top priority
        wr(3, b(5) | b(0));
        line(0, 1'b0);
        idle(4);
        chk(0, b(0) | b(31), "R5 falling edge sets source 0");
        chk(6, 32'd0, "R9 source 0 highest");

        // R4 collision: new edge and clear latch on the same edge
        line(0, 1'b1);
        idle(4);
        line(0, 1'b0);
        @(posedge clk);
        @(posedge clk);
        wr(0, b(0));
        chk(0, b(0) | b(31), "R4 set wins over clear");
        wr(0, b(0));
        chk(0, b(31), "R3 clear without new edge");

        // R2 reserved sources
        line(17, 1'b0);
        line(18, 1'b0);
        line(19, 1'b0);
        idle(4);
        chk(0, b(31), "R2 reserved status stays zero");
        wr(1, 32'hFFFF_FFFF);
        chk(2, b(31), "R2 reserved masked stays zero");
        line(31, 1'b1);
        idle(4);
        wr(0, b(31));
        idle(2);
        chk(K_INT, 0, "R2 reserved never drive int_o");
        chk(K_MCHK, 0, "R2 reserved never drive mchk_o");
        chk(6, 32'hFFFF_FFFF, "R9 none pending");

        idle(3);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule